// File: doc/BRIEF.md
# Fractional-N Feedback Divider with Third-Order Noise Shaping

This block sets the feedback division ratio of a frequency synthesizer. It takes an integer base factor M, a fraction K with FRAC_W bits and a mode bit. In fractional mode the divide value changes from one feedback period to the next, so that the long-run average ratio is M + K/2^FRAC_W. In integer mode the ratio is exactly M. A programmable down-counter runs on the fast clock, loads each new divide value and emits one feedback pulse per period. The noise-shaping modulator advances once per feedback pulse, so it is effectively clocked by the divided clock.

A configuration is written with a one-cycle load strobe. It is held as pending and takes effect at the first period boundary after the strobe. At that boundary the three cascaded accumulators of the modulator restart from zero. Each accumulator's carry passes through a difference network of its own order. The summed result is a signed offset from -3 to +4, which is added to M. The divide value is then clamped so it never falls below 1.

Top module: `fracn_fb_div`

## Requirements
- R1: After reset the applied divide value is 1, mode is integer, and `fb_pulse` is high on every clock cycle until a configuration has been applied.
- R2: `fb_pulse` is high for exactly one cycle per period, and each period lasts exactly the number of clock cycles given by `div_value` at the start of that period.
- R3: With `cfg_frac` = 0 applied, every divide value equals M and `cfg_k` has no effect.
- R4: With `cfg_frac` = 1 and M >= 4, every divide value lies in M-3 .. M+4.
- R5: With `cfg_frac` = 1 and M >= 4, the sum of the first n divide values after an apply stays within -1 .. +2 of M*n + floor(n*K/2^FRAC_W). Over 2^FRAC_W periods this is M*2^FRAC_W + K, within the same bound.
- R6: With `cfg_frac` = 1 and K = 0, every divide value equals M.
- R7: The divide value is never below 1, including for M = 1 in fractional mode.
- R8: A configuration loaded by `cfg_load` takes effect only at the first `fb_pulse` that falls strictly after the load cycle. The period then running completes with the old value.
- R9: Applying a configuration clears the modulator, so the first period after an apply uses exactly M.
- R10: M up to 320 is supported in fractional mode, with values in M-3 .. M+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast (oscillator-side) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_m | input | M_W | Integer base factor M (1..320) |
| cfg_k | input | FRAC_W | Fraction numerator K |
| cfg_frac | input | 1 | 1 = fractional mode, 0 = integer mode |
| cfg_load | input | 1 | One-cycle strobe capturing cfg_m, cfg_k, cfg_frac as pending |
| fb_pulse | output | 1 | One pulse on the last cycle of each feedback period |
| div_value | output | M_W+1 | Divide value of the period in progress |

## Verification
Several properties are checked on every cycle. The counter decrements between pulses and reloads from the new divide value at each pulse. The divide value holds steady within a period, never falls to zero, and matches M whenever integer mode is active. The modulator offset stays inside -3..+4, and integer mode keeps the accumulators at zero. Other behaviours can only be shown by the bench's scenarios over many periods: the cumulative error bound against M*n + floor(n*K/2^FRAC_W), its exact endpoint after 2^FRAC_W periods, fresh restart on every apply, clamping at M = 1, and the delay from a load to its boundary.

// File: rtl/fdiv_pkg.sv
// Shared types for the fractional feedback divider.
// Assumes: the modulator offset never exceeds the range -3..+4.
package fdiv_pkg;
    typedef logic signed [3:0] offset_t;
    localparam int OFFSET_MIN = -3;
    localparam int OFFSET_MAX = 4;
endpackage

// File: rtl/fdiv_acc_stage.sv
// One first-order accumulator stage of the cascaded modulator.
// The sum and carry are combinational from the (optionally cleared) state.
// The state advances only on a step.
// Assumes: clr and zero are only meaningful together with step.
module fdiv_acc_stage #(
    parameter int FRAC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              clr,
    input  logic              zero,
    input  logic [FRAC_W-1:0] din,
    output logic [FRAC_W-1:0] sum_o,
    output logic              carry_o
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] acc_base;

    // Add the input to the state seen by this step; a clear restarts from zero.
    always_comb begin
        acc_base           = clr ? '0 : acc_q;
        {carry_o, sum_o}   = {1'b0, acc_base} + {1'b0, din};
    end

    // Commit the new residue on each step; hold zero when the stage is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (step) acc_q <= zero ? '0 : sum_o;
    end
endmodule

// File: rtl/fdiv_mash3.sv
// Third-order cascaded noise-shaping modulator (three first-order stages).
// Each carry passes through a difference network of its own order:
// c1 + (c2 - c2') + (c3 - 2c3' + c3'').
// Assumes: step comes once per feedback period; clr marks the first step after an apply.
module fdiv_mash3
    import fdiv_pkg::*;
#(
    parameter int FRAC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              clr,
    input  logic              frac_en,
    input  logic [FRAC_W-1:0] k_in,
    output offset_t           offset
);
    localparam int STAGES = 3;

    logic [STAGES-1:0][FRAC_W-1:0] din;
    logic [STAGES-1:0][FRAC_W-1:0] sum;
    logic [STAGES-1:0]             cy;
    logic                          c2_d, c3_d1, c3_d2;
    logic                          c2_b, c3_b1, c3_b2;
    offset_t                       raw;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign din[i] = k_in;
        end else begin : g_next
            assign din[i] = sum[i-1];
        end
        fdiv_acc_stage #(.FRAC_W(FRAC_W)) u_acc (
            .clk(clk), .rst_n(rst_n), .step(step), .clr(clr), .zero(~frac_en),
            .din(din[i]), .sum_o(sum[i]), .carry_o(cy[i])
        );
    end

    // Combine the carries through the difference networks into a signed offset.
    always_comb begin
        c2_b  = clr ? 1'b0 : c2_d;
        c3_b1 = clr ? 1'b0 : c3_d1;
        c3_b2 = clr ? 1'b0 : c3_d2;
        raw   = offset_t'({3'b000, cy[0]})
              + offset_t'({3'b000, cy[1]}) - offset_t'({3'b000, c2_b})
              + offset_t'({3'b000, cy[2]}) - offset_t'({2'b00, c3_b1, 1'b0})
              + offset_t'({3'b000, c3_b2});
        offset = frac_en ? raw : '0;
    end

    // Keep the carry history needed by the second- and third-order networks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c2_d  <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
        end else if (step) begin
            c2_d  <= frac_en ? cy[1] : 1'b0;
            c3_d1 <= frac_en ? cy[2] : 1'b0;
            c3_d2 <= frac_en ? c3_b1 : 1'b0;
        end
    end

    assert_offset_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(offset) >= OFFSET_MIN) && (int'(offset) <= OFFSET_MAX));

    assert_int_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !frac_en) |=> (g_stage[0].u_acc.acc_q == '0) && !c3_d1);
endmodule

// File: rtl/fdiv_fb_counter.sv
// Programmable down-counter producing one pulse per divide period.
// The pulse is on the last cycle; at the pulse it reloads load_val-1.
// Assumes: load_val >= 1 whenever the pulse is high.
module fdiv_fb_counter #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] load_val,
    output logic             pulse
);
    logic [DIV_W-1:0] cnt_q;

    assign pulse = (cnt_q == '0);

    // Count down through the period and reload at its last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (pulse) cnt_q <= load_val - 1'b1;
        else            cnt_q <= cnt_q - 1'b1;
    end

    assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |=> cnt_q == $past(cnt_q) - 1'b1);

    assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> cnt_q == $past(load_val) - 1'b1);

    assert_load_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> load_val != '0);
endmodule

// File: rtl/fracn_fb_div.sv
// Fractional feedback divider top: pending/active configuration, a
// third-order modulator stepped once per period, clamping, and the counter.
// Assumes: cfg_m in 1..2^M_W-1; a load is applied at the next boundary.
module fracn_fb_div
    import fdiv_pkg::*;
#(
    parameter int FRAC_W = 32,
    parameter int M_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [M_W-1:0]    cfg_m,
    input  logic [FRAC_W-1:0] cfg_k,
    input  logic              cfg_frac,
    input  logic              cfg_load,
    output logic              fb_pulse,
    output logic [M_W:0]      div_value
);
    localparam int DIV_W  = M_W + 1;
    localparam int WIDE_W = DIV_W + 2;

    logic              pend_q, act_frac, pend_frac, frac_use, apply;
    logic [M_W-1:0]    pend_m, act_m, m_use;
    logic [FRAC_W-1:0] pend_k, act_k, k_use;
    logic [DIV_W-1:0]  div_q, next_div;
    logic signed [WIDE_W-1:0] wide;
    offset_t           offset;

    assign apply    = fb_pulse && pend_q;
    assign m_use    = apply ? pend_m    : act_m;
    assign k_use    = apply ? pend_k    : act_k;
    assign frac_use = apply ? pend_frac : act_frac;

    // Hold a written configuration until the next period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            pend_m    <= '0;
            pend_k    <= '0;
            pend_frac <= 1'b0;
        end else if (cfg_load) begin
            pend_q    <= 1'b1;
            pend_m    <= cfg_m;
            pend_k    <= cfg_k;
            pend_frac <= cfg_frac;
        end else if (apply) begin
            pend_q    <= 1'b0;
        end
    end

    // Promote the pending configuration to active at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_m    <= M_W'(1);
            act_k    <= '0;
            act_frac <= 1'b0;
        end else if (apply) begin
            act_m    <= pend_m;
            act_k    <= pend_k;
            act_frac <= pend_frac;
        end
    end

    fdiv_mash3 #(.FRAC_W(FRAC_W)) u_mash (
        .clk(clk), .rst_n(rst_n), .step(fb_pulse), .clr(apply),
        .frac_en(frac_use), .k_in(k_use), .offset(offset)
    );

    // Add the signed offset to M and clamp the result at 1.
    always_comb begin
        wide     = $signed({{(WIDE_W-M_W){1'b0}}, m_use})
                 + $signed({{(WIDE_W-4){offset[3]}}, offset});
        next_div = (wide < 1) ? DIV_W'(1) : wide[DIV_W-1:0];
    end

    // Register the divide value of the period that starts after a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= DIV_W'(1);
        else if (fb_pulse) div_q <= next_div;
    end

    fdiv_fb_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_val(next_div), .pulse(fb_pulse)
    );

    assign div_value = div_q;

    assert_div_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_pulse |=> $stable(div_value));

    assert_div_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_value != '0);

    assert_int_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !act_frac |-> div_value == ((act_m == '0) ? DIV_W'(1) : DIV_W'(act_m)));

    assert_apply_fresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && pend_m != '0) |=> div_value == DIV_W'(act_m));
endmodule

// File: tb/tb_fracn_fb_div.sv
// Scoreboard bench: the driver queues each configuration it loads; the monitor
// pops it at the boundary where it takes effect and checks every period.
module tb_fracn_fb_div;
    localparam int FRAC_W   = 8;
    localparam int M_W      = 9;
    localparam int CLK_PER  = 10;
    localparam longint NWIN = 64'd1 << FRAC_W;

    typedef struct { longint m; longint k; bit frac; } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [M_W-1:0]    cfg_m = '0;
    logic [FRAC_W-1:0] cfg_k = '0;
    logic              cfg_frac = 1'b0;
    logic              cfg_load = 1'b0;
    logic              fb_pulse;
    logic [M_W:0]      div_value;

    int errors = 0;
    int checks = 0;
    item_t exp_q[$];

    fracn_fb_div #(.FRAC_W(FRAC_W), .M_W(M_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_m(cfg_m), .cfg_k(cfg_k),
        .cfg_frac(cfg_frac), .cfg_load(cfg_load),
        .fb_pulse(fb_pulse), .div_value(div_value)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: load one configuration, queue it, and wait nper periods past its boundary.
    task automatic load_cfg(input int m, input longint k, input bit frac, input int nper);
        item_t it;
        int seen = 0;
        @(posedge clk); #1;
        cfg_m = M_W'(m); cfg_k = FRAC_W'(k); cfg_frac = frac; cfg_load = 1'b1;
        it.m = m; it.k = k; it.frac = frac;
        exp_q.push_back(it);
        @(posedge clk); #1;
        cfg_load = 1'b0;
        cfg_m = '0; cfg_k = '1; cfg_frac = ~frac;
        while (seen < nper + 1) begin
            @(negedge clk);
            if (fb_pulse) seen++;
        end
    endtask

    // Monitor: checks each finished period against the configuration it belongs to.
    item_t  cur = '{m: 1, k: 0, frac: 1'b0};
    longint n_per = 0;
    longint acc = 0;
    longint since = 0;
    bit     pend = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            since = 0; n_per = 0; acc = 0; pend = 1'b0;
        end else begin
            since++;
            if (fb_pulse) begin
                longint d, dev, lo;
                d = longint'(div_value);
                chk(since == d, "R2", since, d);
                n_per++;
                acc += d;
                if (!cur.frac) begin
                    chk(d == cur.m, "R3 R8", d, cur.m);
                end else begin
                    if (n_per == 1) chk(d == cur.m, "R9", d, cur.m);
                    if (cur.k == 0) chk(d == cur.m, "R6", d, cur.m);
                    chk(d >= 1, "R7", d, 1);
                    lo = (cur.m >= 4) ? cur.m - 3 : 1;
                    chk(d >= lo && d <= cur.m + 4, (cur.m > 255) ? "R10" : "R4", d, cur.m);
                    if (cur.m >= 4) begin
                        dev = acc - cur.m * n_per - ((n_per * cur.k) >> FRAC_W);
                        chk(dev >= -1 && dev <= 2, "R5", dev, 0);
                        if (n_per == NWIN) begin
                            dev = acc - (cur.m * NWIN + cur.k);
                            chk(dev >= -1 && dev <= 2, "R5 window", acc, cur.m * NWIN + cur.k);
                        end
                    end
                end
                if (pend) begin
                    if (exp_q.size() > 0) cur = exp_q.pop_front();
                    n_per = 0; acc = 0; pend = 1'b0;
                end
                since = 0;
            end
            if (cfg_load) pend = 1'b1;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(fb_pulse == 1'b1, "R1 pulse", fb_pulse, 1);
        chk(div_value == 1, "R1 div", div_value, 1);
        repeat (4) @(negedge clk);
        chk(fb_pulse == 1'b1, "R1 idle", fb_pulse, 1);
        load_cfg(9, 200, 1'b0, 20);      // R3: integer, K ignored
        load_cfg(5, 91, 1'b1, 257);      // R4 R5 R9
        load_cfg(12, 255, 1'b1, 257);    // R5 near-full fraction
        load_cfg(7, 1, 1'b1, 257);       // R5 smallest fraction, R8 mid-period load
        load_cfg(6, 0, 1'b1, 30);        // R6
        load_cfg(1, 200, 1'b1, 257);     // R7 clamp
        load_cfg(320, 128, 1'b1, 40);    // R10
        load_cfg(4, 37, 1'b0, 10);       // R3 back to integer
        load_cfg(8, 77, 1'b1, 3);        // closes previous window
        repeat (40) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule